// File: doc/BRIEF.md
# VBI Line Buffer with Ancillary Packet Output

This block sits between a VBI data slicer and the byte-wide output port of a video decoder. The slicer hands over decoded bytes one at a time. The block keeps every byte of the current line in a private buffer until the slicer marks the end of the line. It then raises a request to the output arbiter. When the arbiter grants the port, the block sends the whole line as one ancillary-data packet: a three-byte preamble, a data ID, a byte count, and then the payload, one byte per cycle with no gaps.

A mode input chooses how the payload is sent. In the pass-through mode the payload bytes are sent as stored. In the clean mode the two reserved values 00h and FFh are replaced by 03h and FCh, so the payload can never look like a timing code. The arbiter is expected to favour this packet over video when both are ready.

The buffer holds one line. Bytes beyond its depth are dropped, and a sticky error bit records that this happened. The data ID is a parameter. `DEPTH` must not exceed 255, so that the count fits in one byte.

Top module: `vbi_anc_packer`

## Requirements
- R1: After reset, `req`, `out_valid`, `vbi_flag` and `ovf_err` are 0, `in_ready` is 1, and `out_data` is 00h.
- R2: While `in_ready` is high, each cycle with `in_valid` high stores `in_data` as the next payload byte. A byte presented in the same cycle as `in_eol` is part of that line.
- R3: `in_eol` sampled high while `in_ready` is high, with at least one byte in the line, raises `req` in the next cycle. `in_eol` on an empty line leaves `req` low and the block collecting.
- R4: `req` stays high from line completion through the cycle of the last payload byte, and is low in the cycle after it.
- R5: `out_valid` rises only in the cycle after `gnt` was sampled high while the line was waiting. From then on the packet is driven on consecutive cycles with no idle cycle, whatever `gnt` does.
- R6: The packet starts with the bytes 00h, FFh, FFh, then the `DID` parameter, then the number of payload bytes. These five header bytes are never recoded.
- R7: With `recode_en` = 0, each payload byte equals the stored byte, in arrival order.
- R8: With `recode_en` = 1, a stored 00h is sent as 03h and a stored FFh is sent as FCh. All other values are sent unchanged.
- R9: `vbi_flag` is high exactly in the cycles that carry payload bytes. It is low during the header and while idle.
- R10: Bytes that arrive when `DEPTH` bytes are already stored are dropped, and the count byte reports `DEPTH`. A drop sets `ovf_err`, which stays high until reset.
- R11: From line completion until the packet has been sent, `in_ready` is low, and `in_valid`, `in_data` and `in_eol` have no effect on the packet or on the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Slicer byte valid |
| in_data | input | 8 | Slicer byte |
| in_eol | input | 1 | End-of-line strobe from the slicer |
| in_ready | output | 1 | High while the block accepts slicer bytes |
| recode_en | input | 1 | 1: replace 00h/FFh in the payload; 0: send the payload as stored |
| req | output | 1 | Request to the output arbiter |
| gnt | input | 1 | Grant from the output arbiter |
| out_valid | output | 1 | Packet byte on `out_data` |
| out_data | output | 8 | Output byte stream |
| vbi_flag | output | 1 | The current byte is VBI payload |
| ovf_err | output | 1 | Sticky: a line overflowed the buffer |

## Verification
The assertions check these rules on every cycle:
- collecting and requesting never overlap;
- every output byte falls inside the request window;
- a burst starts only after a grant;
- the header is always followed by another byte;
- the payload never carries 00h or FFh in the clean mode;
- the error bit stays set once raised.

Only the bench scenarios can show the values that need to know what went in. These are the exact header, the byte count, the payload order and contents for every line length from 1 to the buffer depth in both modes, the drop rule on an over-long line, and the fact that input offered during a pending packet changes nothing.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_WAIT    = 2'd1,
    ST_BURST   = 2'd2
  } vbi_state_e;

  localparam int unsigned HDR_LEN = 5;
  localparam logic [7:0]  PRE_LO  = 8'h00;
  localparam logic [7:0]  PRE_HI  = 8'hFF;
endpackage

// File: rtl/vbi_line_fifo.sv
module vbi_line_fifo #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          clr,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, do_wr;

  assign full  = (cnt_q == CW'(DEPTH));
  assign do_wr = wr_en && !full;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (do_wr) cnt_d = cnt_q + CW'(1);
    ovf_d = ovf_q | (wr_en & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[cnt_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
  assign count   = cnt_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/vbi_recode.sv
module vbi_recode (
  input  logic       mode,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  always_comb begin
    dout = din;
    if (mode) begin
      if (din == 8'h00)      dout = 8'h03;
      else if (din == 8'hFF) dout = 8'hFC;
    end
  end
endmodule

// File: rtl/vbi_anc_seq.sv
module vbi_anc_seq
  import vbi_anc_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter logic [7:0]  DID   = 8'h61,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned IW = $clog2(DEPTH + HDR_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eol,
  input  logic          line_has,
  input  logic [CW-1:0] count,
  input  logic          gnt,
  output logic          collecting,
  output logic          req,
  output logic          burst,
  output logic          payload,
  output logic          clr,
  output logic [AW-1:0] rd_idx,
  output logic [7:0]    hdr_byte
);
  vbi_state_e    state_q, state_d;
  logic [IW-1:0] pos_q, pos_d;
  logic          last;

  assign last = (pos_q == IW'(count) + IW'(HDR_LEN - 1));

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    unique case (state_q)
      ST_COLLECT: if (eol && line_has) state_d = ST_WAIT;
      ST_WAIT: if (gnt) begin
        state_d = ST_BURST;
        pos_d   = '0;
      end
      ST_BURST: begin
        pos_d = pos_q + IW'(1);
        if (last) state_d = ST_COLLECT;
      end
      default: state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  assign collecting = (state_q == ST_COLLECT);
  assign req        = !collecting;
  assign burst      = (state_q == ST_BURST);
  assign payload    = burst && (pos_q >= IW'(HDR_LEN));
  assign clr        = burst && last;
  assign rd_idx     = payload ? AW'(pos_q - IW'(HDR_LEN)) : '0;

  always_comb begin
    unique case (pos_q[2:0])
      3'd1, 3'd2: hdr_byte = PRE_HI;
      3'd3:       hdr_byte = DID;
      3'd4:       hdr_byte = 8'(count);
      default:    hdr_byte = PRE_LO;
    endcase
  end
endmodule

// File: rtl/vbi_anc_packer.sv
module vbi_anc_packer #(
  parameter int unsigned DEPTH = 64,
  parameter logic [7:0]  DID   = 8'h61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_eol,
  output logic       in_ready,
  input  logic       recode_en,
  output logic       req,
  input  logic       gnt,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       vbi_flag,
  output logic       ovf_err
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          wr_en, clr, burst, payload, collecting;
  logic [AW-1:0] rd_idx;
  logic [7:0]    rd_data, rec_data, hdr_byte;
  logic [CW-1:0] count;

  assign wr_en = in_valid && collecting;

  vbi_line_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_data), .clr(clr),
    .rd_idx(rd_idx), .rd_data(rd_data), .count(count), .ovf(ovf_err)
  );

  vbi_anc_seq #(.DEPTH(DEPTH), .DID(DID)) u_seq (
    .clk(clk), .rst_n(rst_n), .eol(in_eol),
    .line_has((count != '0) || wr_en), .count(count), .gnt(gnt),
    .collecting(collecting), .req(req), .burst(burst), .payload(payload),
    .clr(clr), .rd_idx(rd_idx), .hdr_byte(hdr_byte)
  );

  vbi_recode u_rec (.mode(recode_en), .din(rd_data), .dout(rec_data));

  assign in_ready  = collecting;
  assign out_valid = burst;
  assign vbi_flag  = payload;
  assign out_data  = !burst ? 8'h00 : (payload ? rec_data : hdr_byte);
endmodule

// File: rtl/vbi_anc_packer_chk.sv
module vbi_anc_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_eol,
  input logic       in_ready,
  input logic       recode_en,
  input logic       req,
  input logic       gnt,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       vbi_flag,
  input logic       ovf_err
);
  // R11
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && req));
  // R4
  req_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> req);
  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(vbi_flag));
  // R3
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(in_eol));
  // R5
  start_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(gnt));
  // R5
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !vbi_flag) |=> out_valid);
  // R8
  clean_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vbi_flag && recode_en) |-> (out_data != 8'h00 && out_data != 8'hFF));
  // R9
  flag_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vbi_flag |-> out_valid);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

bind vbi_anc_packer vbi_anc_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_eol(in_eol), .in_ready(in_ready),
  .recode_en(recode_en), .req(req), .gnt(gnt), .out_valid(out_valid),
  .out_data(out_data), .vbi_flag(vbi_flag), .ovf_err(ovf_err)
);

// File: tb/sim_vbi_anc_packer.sv
module sim_vbi_anc_packer;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam logic [7:0] DID = 8'h61;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_eol = 1'b0, recode_en = 1'b0, gnt = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, req, out_valid, vbi_flag, ovf_err;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  vbi_anc_packer #(.DEPTH(DEPTH), .DID(DID)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_eol(in_eol), .in_ready(in_ready), .recode_en(recode_en), .req(req),
    .gnt(gnt), .out_valid(out_valid), .out_data(out_data),
    .vbi_flag(vbi_flag), .ovf_err(ovf_err)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    case (i % 4)
      0: return 8'h00;
      1: return 8'hFF;
      default: return 8'((i * 29 + seed) & 255);
    endcase
  endfunction

  function automatic logic [7:0] expect_pay(input logic [7:0] b, input bit m);
    if (m && b == 8'h00) return 8'h03;
    if (m && b == 8'hFF) return 8'hFC;
    return b;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; in_eol = 1'b0; gnt = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  // Send one line of n bytes, hold off wcyc cycles, then grant and compare.
  task automatic run_line(input int n, input int seed, input bit mode, input int wcyc);
    int stored;
    stored = (n > DEPTH) ? DEPTH : n;
    recode_en = mode;
    for (int i = 0; i < n; i++) begin
      check(in_ready == 1'b1, "R2 in_ready while collecting", in_ready, 1);
      in_valid = 1'b1; in_data = pat(i, seed); in_eol = (i == n - 1);
      step();
    end
    in_valid = 1'b0; in_eol = 1'b0;
    if (n == 0) begin
      in_eol = 1'b1;
      step();
      in_eol = 1'b0;
      check(req == 1'b0, "R3 empty eol no request", req, 0);
      check(in_ready == 1'b1, "R3 empty eol still collecting", in_ready, 1);
      return;
    end
    check(req == 1'b1, "R3 req after eol", req, 1);
    check(in_ready == 1'b0, "R11 in_ready low when pending", in_ready, 0);
    for (int w = 0; w < wcyc; w++) begin
      in_valid = 1'b1; in_data = 8'hA5; in_eol = 1'b1;
      step();
      check(out_valid == 1'b0, "R5 no output before grant", out_valid, 0);
      check(req == 1'b1, "R4 req held while waiting", req, 1);
    end
    in_valid = 1'b0; in_eol = 1'b0;
    gnt = 1'b1;
    step();
    gnt = 1'b0;
    for (int p = 0; p < 5 + stored; p++) begin
      logic [7:0] e;
      case (p)
        0: e = 8'h00;
        1, 2: e = 8'hFF;
        3: e = DID;
        4: e = 8'(stored);
        default: e = expect_pay(pat(p - 5, seed), mode);
      endcase
      in_valid = 1'b1; in_data = 8'h5A; in_eol = 1'b1;
      check(out_valid == 1'b1, "R5 contiguous burst", out_valid, 1);
      if (p < 5) check(out_data == e, "R6 header byte", out_data, e);
      else if (mode) check(out_data == e, "R8 recoded payload", out_data, e);
      else check(out_data == e, "R7 direct payload", out_data, e);
      check(vbi_flag == (p >= 5), "R9 vbi_flag on payload only", vbi_flag, (p >= 5));
      check(req == 1'b1, "R4 req during burst", req, 1);
      step();
    end
    in_valid = 1'b0; in_eol = 1'b0;
    check(req == 1'b0, "R4 req low after last byte", req, 0);
    check(out_valid == 1'b0, "R5 burst ends", out_valid, 0);
    check(in_ready == 1'b1, "R11 collecting again", in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P/4);
    check(req == 1'b0, "R1 reset req", req, 0);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(vbi_flag == 1'b0, "R1 reset vbi_flag", vbi_flag, 0);
    check(ovf_err == 1'b0, "R1 reset ovf_err", ovf_err, 0);
    check(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    check(out_data == 8'h00, "R1 reset out_data", out_data, 0);
    do_reset();
    for (int m = 0; m < 2; m++)
      for (int n = 1; n <= DEPTH; n++)
        run_line(n, n * 7 + m, m[0], n % 3);
    run_line(0, 0, 1'b0, 0);
    check(ovf_err == 1'b0, "R10 no error without overflow", ovf_err, 0);
    run_line(DEPTH + 6, 11, 1'b1, 2);
    check(ovf_err == 1'b1, "R10 overflow sets error", ovf_err, 1);
    run_line(3, 5, 1'b0, 1);
    check(ovf_err == 1'b1, "R10 error sticky", ovf_err, 1);
    do_reset();
    check(ovf_err == 1'b0, "R10 reset clears error", ovf_err, 0);
    run_line(1, 2, 1'b1, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule